// File: doc/BRIEF.md
# LCD Polarity Alternation Generator

This block produces the polarity-alternation signal that an LCD row/column driver pair uses to reverse drive polarity and so limit crosstalk. It runs on a system clock and sees the display's line clock and frame marker as one-cycle strobes. A 6-bit line-period setting chooses how many lines pass between polarity inversions, from 2 to 63. A select input can also invert the polarity once per frame. The output is then the exclusive OR of the line waveform and a frame waveform.

When the line-period setting is 0 or 1, or when the block is in follower (slave) mode, internal generation stops. The output enable goes low and the polarity output passes the externally supplied polarity straight through. In that state the line counter and both internal waveforms are held cleared. Generation therefore restarts from a known phase when it is enabled again.

Top module: `lcdac_polarity_gen`

## Requirements
- R1: With a line-period setting N in 2..63, internal generation enabled and the frame-XOR select low, the polarity output starts low and inverts on the clock edge that takes in every Nth line strobe, and at no other time.
- R2: A line-period setting of 0 or 1 disables internal generation: the output enable is low and the polarity output equals the external polarity input in the same cycle, whatever the strobes do.
- R3: In follower mode (slave input high) internal generation is disabled for every line-period setting and either frame-XOR select value: the output enable is low and the polarity output equals the external polarity input.
- R4: With the frame-XOR select low, frame strobes have no effect on the polarity output.
- R5: With the frame-XOR select high, the polarity output is the line waveform XOR a frame waveform, and the frame waveform inverts on each frame strobe taken in while generation is enabled.
- R6: If the line-period setting is lowered below the number of lines already counted, the next line strobe inverts the line waveform and restarts the count from zero.
- R7: Reset (active low, asynchronous) clears the line count and both waveforms, so the polarity output is low while generation is enabled.
- R8: While generation is disabled the line count and both waveforms stay cleared. After re-enable, the first inversion comes N line strobes later and starts from low.
- R9: A line strobe that completes a period and a frame strobe in the same cycle both take effect. With the frame-XOR select high, the polarity output is then unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle strobe per display line |
| frame_stb | input | 1 | One-cycle strobe per frame |
| line_count | input | CNT_W (6) | Lines between inversions; 0 or 1 disables generation |
| xor_frame | input | 1 | High: XOR the per-frame waveform into the output |
| slave_mode | input | 1 | High: follower mode, polarity taken from outside |
| pol_in | input | 1 | External polarity used when generation is disabled |
| pol_out | output | 1 | Polarity alternation signal |
| pol_oe | output | 1 | High when pol_out is generated internally |

## Verification
On every cycle, the assertions check several relations. The output enable must drop for short settings and in follower mode, and the output must follow the external polarity whenever the enable is low. The line waveform may change only on a period-completing strobe, and it must change then. The frame waveform must invert on each enabled frame strobe. Everything must be cleared one cycle after generation is disabled, and the output must equal the line waveform, or its XOR with the frame waveform, per the select. Only the bench's scenarios show the exact inversion phase over long runs, including 63-line periods. The same holds for lowering the period mid-count, the restart after re-enable or a mid-run reset, and coincident line and frame strobes.

// File: rtl/lcdac_pkg.sv
package lcdac_pkg;

  typedef enum logic {
    POL_SRC_EXT = 1'b0,
    POL_SRC_INT = 1'b1
  } pol_src_e;

  // Combine line and frame waveforms according to the XOR select.
  function automatic logic mix_polarity(input logic line_w, input logic frame_w,
                                        input logic use_frame);
    return line_w ^ (use_frame & frame_w);
  endfunction

endpackage

// File: rtl/lcdac_mode_ctl.sv
module lcdac_mode_ctl
  import lcdac_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int MIN_PERIOD = 2
) (
  input  logic             slave_mode,
  input  logic [CNT_W-1:0] line_count,
  output logic             gen_en,
  output pol_src_e         pol_src
);

  localparam logic [CNT_W-1:0] MinCount = CNT_W'(MIN_PERIOD);

  always_comb begin
    gen_en  = !slave_mode && (line_count >= MinCount);
    pol_src = gen_en ? POL_SRC_INT : POL_SRC_EXT;
  end

endmodule

// File: rtl/lcdac_line_div.sv
module lcdac_line_div #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             line_stb,
  input  logic [CNT_W-1:0] period,
  output logic             line_wave,
  output logic             line_wrap,
  output logic [CNT_W-1:0] line_pos
);

  localparam int EXT_W = CNT_W + 1;

  // True when the line now being taken in closes the period (or overshoots it).
  function automatic logic period_done(input logic [CNT_W-1:0] pos,
                                       input logic [CNT_W-1:0] per);
    logic [EXT_W-1:0] next_pos;
    next_pos = {1'b0, pos} + EXT_W'(1);
    return next_pos >= {1'b0, per};
  endfunction

  assign line_wrap = gen_en && line_stb && period_done(line_pos, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_pos  <= '0;
      line_wave <= 1'b0;
    end else if (!gen_en) begin
      line_pos  <= '0;
      line_wave <= 1'b0;
    end else if (line_stb) begin
      if (line_wrap) begin
        line_pos  <= '0;
        line_wave <= ~line_wave;
      end else begin
        line_pos  <= line_pos + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lcdac_frame_tgl.sv
module lcdac_frame_tgl (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_en,
  input  logic frame_stb,
  output logic frame_wave
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frame_wave <= 1'b0;
    else if (!gen_en)
      frame_wave <= 1'b0;
    else if (frame_stb)
      frame_wave <= ~frame_wave;
  end

endmodule

// File: rtl/lcdac_polarity_gen.sv
module lcdac_polarity_gen
  import lcdac_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int MIN_PERIOD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic             frame_stb,
  input  logic [CNT_W-1:0] line_count,
  input  logic             xor_frame,
  input  logic             slave_mode,
  input  logic             pol_in,
  output logic             pol_out,
  output logic             pol_oe
);

  logic             gen_en;
  pol_src_e         pol_src;
  logic             line_wave;
  logic             line_wrap;
  logic [CNT_W-1:0] line_pos;
  logic             frame_wave;

  lcdac_mode_ctl #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) mode_i (
    .slave_mode (slave_mode),
    .line_count (line_count),
    .gen_en     (gen_en),
    .pol_src    (pol_src)
  );

  lcdac_line_div #(.CNT_W(CNT_W)) line_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .line_stb  (line_stb),
    .period    (line_count),
    .line_wave (line_wave),
    .line_wrap (line_wrap),
    .line_pos  (line_pos)
  );

  lcdac_frame_tgl frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .frame_stb  (frame_stb),
    .frame_wave (frame_wave)
  );

  always_comb begin
    pol_oe = (pol_src == POL_SRC_INT);
    if (pol_src == POL_SRC_INT)
      pol_out = mix_polarity(line_wave, frame_wave, xor_frame);
    else
      pol_out = pol_in;
  end

endmodule

// File: rtl/lcdac_polarity_chk.sv
module lcdac_polarity_chk #(
  parameter int CNT_W      = 6,
  parameter int MIN_PERIOD = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slave_mode,
  input logic             xor_frame,
  input logic [CNT_W-1:0] line_count,
  input logic             frame_stb,
  input logic             pol_in,
  input logic             pol_out,
  input logic             pol_oe,
  input logic             gen_en,
  input logic             line_wrap,
  input logic             line_wave,
  input logic             frame_wave,
  input logic [CNT_W-1:0] line_pos
);

  localparam logic [CNT_W-1:0] MinCount = CNT_W'(MIN_PERIOD);

  assert_short_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_count < MinCount) |-> !pol_oe);

  assert_ext_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_oe |-> (pol_out == pol_in));

  assert_slave_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> !pol_oe);

  assert_line_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !line_wrap) |=> $stable(line_wave));

  assert_line_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap |=> (line_wave != $past(line_wave)));

  assert_plain_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_oe && !xor_frame) |-> (pol_out == line_wave));

  assert_frame_xor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_oe && xor_frame) |-> (pol_out == (line_wave ^ frame_wave)));

  assert_frame_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && frame_stb) |=> (frame_wave != $past(frame_wave)));

  assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && (line_pos < line_count)) |=>
      (!gen_en || (line_count != $past(line_count)) || (line_pos < line_count)));

  assert_clear_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!line_wave && !frame_wave && (line_pos == '0)));

endmodule

bind lcdac_polarity_gen lcdac_polarity_chk #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .slave_mode (slave_mode),
  .xor_frame  (xor_frame),
  .line_count (line_count),
  .frame_stb  (frame_stb),
  .pol_in     (pol_in),
  .pol_out    (pol_out),
  .pol_oe     (pol_oe),
  .gen_en     (gen_en),
  .line_wrap  (line_wrap),
  .line_wave  (line_wave),
  .frame_wave (frame_wave),
  .line_pos   (line_pos)
);

// File: tb/lcdac_polarity_gen_tb.sv
module lcdac_polarity_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0;
  logic       frame_stb = 1'b0;
  logic [5:0] line_count = 6'd3;
  logic       xor_frame = 1'b0;
  logic       slave_mode = 1'b0;
  logic       pol_in = 1'b0;
  logic       pol_out;
  logic       pol_oe;

  always #5 clk = ~clk;

  lcdac_polarity_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_stb   (line_stb),
    .frame_stb  (frame_stb),
    .line_count (line_count),
    .xor_frame  (xor_frame),
    .slave_mode (slave_mode),
    .pol_in     (pol_in),
    .pol_out    (pol_out),
    .pol_oe     (pol_oe)
  );

  int checks = 0;
  int fails  = 0;

  // staged configuration, applied by the driver at the next falling edge
  int   s_count = 3;
  logic s_xor   = 1'b0;
  logic s_slave = 1'b0;
  logic s_pin   = 1'b0;

  // reference model state
  int   m_lines = 0;
  logic m_lw    = 1'b0;
  logic m_fw    = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  task automatic step(input logic ln, input logic fr, input string tag);
    bit en;
    logic exp_pol;
    @(negedge clk);
    line_count = 6'(s_count);
    xor_frame  = s_xor;
    slave_mode = s_slave;
    pol_in     = s_pin;
    line_stb   = ln;
    frame_stb  = fr;
    en = (s_slave == 1'b0) && (s_count > 1);
    if (!en) begin
      m_lines = 0; m_lw = 1'b0; m_fw = 1'b0;
    end else begin
      if (ln) begin
        m_lines = m_lines + 1;
        if (m_lines >= s_count) begin
          m_lines = 0;
          m_lw = !m_lw;
        end
      end
      if (fr) m_fw = !m_fw;
    end
    if (en) exp_pol = s_xor ? (m_lw ^ m_fw) : m_lw;
    else    exp_pol = s_pin;
    exp_q.push_back({en, exp_pol});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  task automatic lines(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, tag);
      step(1'b0, 1'b0, tag);
    end
  endtask

  // monitor: compares outputs a little after each rising edge
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({pol_oe, pol_out} !== e) begin
        fails++;
        $display("FAIL %s: oe/pol actual %b%b expected %b%b", t, pol_oe, pol_out, e[1], e[0]);
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (pol_out !== 1'b0 || pol_oe !== 1'b1) begin
      fails++;
      $display("FAIL %s: oe/pol actual %b%b expected 10", tag, pol_oe, pol_out);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R7: state held in reset
    #12;
    check_reset("R7 in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: period 3, nine lines with idle gaps
    s_count = 3;
    lines(9, "R1 period 3");
    idle(2, "R1 idle");
    // R1: period 2
    s_count = 2;
    lines(4, "R1 period 2");

    // R4: frame strobes ignored when select low
    s_count = 4;
    step(1'b0, 1'b1, "R4 frame strobe");
    step(1'b0, 1'b1, "R4 frame strobe");
    step(1'b0, 1'b1, "R4 frame strobe");
    lines(4, "R4 lines");

    // R5: select high, frame waveform XORed
    s_xor = 1'b1;
    idle(1, "R5 select on");
    step(1'b0, 1'b1, "R5 frame strobe");
    lines(3, "R5 lines");
    step(1'b0, 1'b1, "R5 frame strobe");
    lines(5, "R5 lines");

    // R9: coincident completing line strobe and frame strobe
    s_count = 2;
    step(1'b1, 1'b0, "R9 line");
    step(1'b1, 1'b1, "R9 coincident");
    idle(1, "R9 after");

    // R2: counts 0 and 1 pass external polarity
    s_xor = 1'b0;
    s_count = 0;
    s_pin = 1'b1; step(1'b1, 1'b1, "R2 count 0");
    s_pin = 1'b0; step(1'b1, 1'b0, "R2 count 0");
    s_count = 1;
    s_pin = 1'b1; step(1'b1, 1'b1, "R2 count 1");
    s_pin = 1'b0; step(1'b0, 1'b1, "R2 count 1");

    // R3: follower mode
    s_slave = 1'b1;
    s_count = 5;
    s_xor = 1'b1;
    s_pin = 1'b1; step(1'b1, 1'b1, "R3 slave");
    s_pin = 1'b0; step(1'b1, 1'b0, "R3 slave");
    s_pin = 1'b1; lines(3, "R3 slave lines");
    s_slave = 1'b0;
    s_xor = 1'b0;
    s_pin = 1'b0;

    // R8: cleared while disabled, restarts from phase zero
    s_count = 4;
    lines(2, "R8 before off");
    s_count = 0;
    idle(1, "R8 off");
    s_count = 4;
    lines(8, "R8 re-enable");

    // R6: period lowered below current position
    s_count = 10;
    lines(6, "R6 count 10");
    s_count = 3;
    lines(4, "R6 lowered to 3");

    // R1: longest period
    s_count = 63;
    idle(1, "R1 period 63 start");
    for (int i = 0; i < 130; i++) step(1'b1, 1'b0, "R1 period 63");

    // R7: mid-run reset
    s_count = 3;
    lines(2, "R7 pre reset");
    @(negedge clk);
    rst_n = 1'b0;
    m_lines = 0; m_lw = 1'b0; m_fw = 1'b0;
    #1;
    check_reset("R7 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    lines(6, "R7 after reset");

    idle(3, "end");
    @(negedge clk);
    finish_run();
  end

endmodule